// File: doc/BRIEF.md
# Four-Lane Serial ADC Capture Interface

This block collects the results of four serial successive-approximation converters that sample at the same instant. One shared conversion-complete strobe starts a readout sequencer. The sequencer clocks all four serial data lanes together into per-lane shift registers. When the last bit is in, it copies every lane into its own holding buffer in a single cycle and raises a one-cycle interrupt pulse.

The host picks a lane with a two-bit address and gets that lane's held word back combinationally. Each lane is double-buffered, so the host can keep reading the previous set of results while the next set is still shifting in. Words are 16-bit two's complement. The first serial bit becomes bit 15 of the host word, which is the sign bit.

Top module: `adc_capture_if`

## Requirements
- R1: After reset every holding buffer reads 0x0000 on all four addresses, `irq` is 0, `sclk_en` is 0, and the sequencer is idle.
- R2: When `conv_done` is sampled high while the sequencer is idle, the next cycle is a start cycle with `sclk_en` low. `sclk_en` is then high for exactly 16 consecutive cycles.
- R3: In each cycle where `sclk_en` is high, lane n samples `sdata[n]` on the rising clock edge. The four lanes are sampled in the same cycles, most significant bit first, so the first bit becomes bit 15 (the sign) of the stored word.
- R4: The holding buffers take the new words at the edge 18 cycles after the edge that accepted `conv_done`. `irq` is high for exactly that one following cycle and low otherwise.
- R5: Until that load edge, every holding buffer keeps its previous word, including during all 16 shift cycles and the load cycle.
- R6: `conv_done` sampled high while a readout is in progress (start, shift or load cycle) is ignored. The transfer timing does not change, and no new readout follows once the sequencer is idle again.
- R7: `rd_data` is the holding buffer of lane `rd_addr` (0 to 3) and follows a change of `rd_addr` with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial and system clock (nominally 40 MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_done | input | 1 | Shared conversion-complete indication from the converters |
| sdata | input | 4 | Serial data lanes, one bit per converter |
| sclk_en | output | 1 | High in each cycle a data bit is shifted; the converters advance on it |
| irq | output | 1 | One-cycle pulse when the holding buffers are loaded |
| rd_addr | input | 2 | Host lane select |
| rd_data | output | 16 | Held word of the selected lane |

## Verification
Two functions meet in the load cycle: a host read and the buffer load. The bench reads all four lanes in the cycle just before the load edge and again in the cycle the pulse is high, and expects the old words and then the new words. A second collision places a completion strobe in the shift window and in the load cycle itself. It is judged by the unchanged shift length, the pulse timing, and the absence of a follow-on readout.

// File: rtl/adc_capture_pkg.sv
// Package: shared types for the serial ADC capture interface.
// Assumes: nothing beyond the synthesizable subset.
package adc_capture_pkg;

    // Readout sequencer states
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_START = 2'd1,
        SEQ_SHIFT = 2'd2,
        SEQ_LOAD  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/adc_capture_seq.sv
// Module: adc_capture_seq
// Readout sequencer. It accepts a completion strobe when idle, spends one
// start cycle, then DW shift cycles, then one load cycle, and registers the
// interrupt pulse so that it shows in the cycle after the load edge.
// Assumes: conv_done is synchronous to clk.
module adc_capture_seq
    import adc_capture_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_done,
    output logic shift_en,
    output logic load_en,
    output logic busy,
    output logic irq
);

    localparam int CNT_W = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);

    seq_state_t       state_q;
    seq_state_t       state_d;
    logic [CNT_W-1:0] bit_cnt_q;

    // Next-state decode
    always_comb begin
        state_d = state_q;
        case (state_q)
            SEQ_IDLE:  if (conv_done) state_d = SEQ_START;
            SEQ_START: state_d = SEQ_SHIFT;
            SEQ_SHIFT: if (bit_cnt_q == LAST_BIT) state_d = SEQ_LOAD;
            SEQ_LOAD:  state_d = SEQ_IDLE;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Shift bit counter, cleared outside the shift phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
        end else if (state_q == SEQ_SHIFT) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
        end else begin
            bit_cnt_q <= '0;
        end
    end

    // Interrupt pulse registered off the load cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= (state_q == SEQ_LOAD);
        end
    end

    // Strobes to the lanes
    always_comb begin
        shift_en = (state_q == SEQ_SHIFT);
        load_en  = (state_q == SEQ_LOAD);
        busy     = (state_q != SEQ_IDLE);
    end

endmodule

// File: rtl/adc_capture_lane.sv
// Module: adc_capture_lane
// One converter lane: a serial-in shift register, MSB first, and a holding
// buffer loaded from it in one cycle.
// Assumes: shift_en and load_en are never high in the same cycle.
module adc_capture_lane #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          load_en,
    input  logic          sdi,
    output logic [DW-1:0] held
);

    logic [DW-1:0] shreg_q;

    // Serial-to-parallel shift, first bit ends up in the MSB
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (shift_en) begin
            shreg_q <= {shreg_q[DW-2:0], sdi};
        end
    end

    // Holding buffer, updated only on the load strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (load_en) begin
            held <= shreg_q;
        end
    end

endmodule

// File: rtl/adc_capture_rdmux.sv
// Module: adc_capture_rdmux
// Combinational host read selector over the lane holding buffers.
// Assumes: sel never exceeds NCH-1 for a non-power-of-two lane count.
module adc_capture_rdmux #(
    parameter int NCH = 4,
    parameter int DW  = 16,
    parameter int AW  = 2
) (
    input  logic [NCH-1:0][DW-1:0] words,
    input  logic [AW-1:0]          sel,
    output logic [DW-1:0]          dout
);

    // Select one lane, zero for an out-of-range address
    always_comb begin
        dout = '0;
        for (int i = 0; i < NCH; i++) begin
            if (sel == AW'(i)) dout = words[i];
        end
    end

endmodule

// File: rtl/adc_capture_if.sv
// Module: adc_capture_if (top)
// Four-lane capture of synchronously sampled serial SAR results with
// double buffering, a load interrupt and a combinational host read port.
// Assumes: all inputs synchronous to clk; the converters present the next
// bit after each cycle in which sclk_en is high.
module adc_capture_if #(
    parameter int NCH = 4,
    parameter int DW  = 16,
    parameter int AW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           conv_done,
    input  logic [NCH-1:0] sdata,
    output logic           sclk_en,
    output logic           irq,
    input  logic [AW-1:0]  rd_addr,
    output logic [DW-1:0]  rd_data
);

    logic                   shift_en;
    logic                   load_en;
    logic                   seq_busy;
    logic [NCH-1:0][DW-1:0] held_words;

    adc_capture_seq #(.DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .shift_en  (shift_en),
        .load_en   (load_en),
        .busy      (seq_busy),
        .irq       (irq)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        adc_capture_lane #(.DW(DW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .load_en  (load_en),
            .sdi      (sdata[g]),
            .held     (held_words[g])
        );
    end

    adc_capture_rdmux #(.NCH(NCH), .DW(DW), .AW(AW)) u_rdmux (
        .words (held_words),
        .sel   (rd_addr),
        .dout  (rd_data)
    );

    // Serial clock enable toward the converters
    always_comb sclk_en = shift_en;

endmodule

// File: rtl/adc_capture_if_chk.sv
// Module: adc_capture_if_chk
// Temporal checks on the capture interface, bound to the top module.
// Assumes: synchronous active-low reset on rst_n.
module adc_capture_if_chk #(
    parameter int DW = 16,
    parameter int AW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          conv_done,
    input logic          sclk_en,
    input logic          irq,
    input logic          seq_busy,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] rd_data
);

    localparam int RW = $clog2(DW + 1) + 1;
    logic [RW-1:0] run_q;

    // Length of the current sclk_en run
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else if (sclk_en) run_q <= run_q + 1'b1;
        else run_q <= '0;
    end

    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !seq_busy) |=> (seq_busy && !sclk_en)); // R2
    AST_SHIFT_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_busy) |=> sclk_en); // R2
    AST_SHIFT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_en) |-> (run_q == RW'(DW))); // R2
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R4
    AST_IRQ_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_en) |=> irq); // R4
    AST_HOLD_UNTIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && $stable(rd_addr)) |-> $stable(rd_data)); // R5
    AST_BUSY_IGNORES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_en && conv_done) |=> (sclk_en || seq_busy)); // R6

endmodule

bind adc_capture_if adc_capture_if_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_done (conv_done),
    .sclk_en   (sclk_en),
    .irq       (irq),
    .seq_busy  (seq_busy),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
);

// File: tb/adc_capture_if_bench.sv
// Directed bench for adc_capture_if with a behavioural four-lane converter model.
module adc_capture_if_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [3:0]  sdata = 4'h0;
    logic        sclk_en;
    logic        irq;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0][15:0] cw = '0;     // words the converters will send
    logic [3:0][15:0] last_w = '0; // words expected in the buffers now
    int bit_idx = 0;

    always #10 clk = ~clk; // 50 MHz

    adc_capture_if u_adc_capture_if (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .sdata(sdata),
        .sclk_en(sclk_en), .irq(irq), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Converter model: present the next bit, MSB first, while shifting
    always @(negedge clk) begin
        if (sclk_en) begin
            for (int c = 0; c < 4; c++) sdata[c] = cw[c][15 - bit_idx];
            bit_idx = bit_idx + 1;
        end else begin
            bit_idx = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Read all lanes through the host port and compare (R7)
    task automatic read_all(input string tag, input logic [3:0][15:0] exp);
        for (int c = 0; c < 4; c++) begin
            rd_addr = 2'(c);
            #1;
            chk(tag, {16'h0, rd_data}, {16'h0, exp[c]});
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", {31'h0, irq}, 32'h0);
        chk("R1 sclk_en after reset", {31'h0, sclk_en}, 32'h0);
        read_all("R1 buffers zero after reset", '0);
        last_w = '0;
    endtask

    // One readout; poke places extra completion strobes in the busy window
    task automatic t_xfer(input logic [3:0][15:0] w, input bit poke);
        cw = w;
        conv_done = 1'b1;
        for (int j = 0; j <= 20; j++) begin
            @(negedge clk);
            chk($sformatf("R2 sclk_en j=%0d", j), {31'h0, sclk_en},
                {31'h0, (j >= 1 && j <= 16)});
            chk($sformatf("R4 irq j=%0d", j), {31'h0, irq}, {31'h0, (j == 18)});
            if (j == 10) read_all("R5 old words mid-shift", last_w);
            if (j == 17) read_all("R5 old words in load cycle", last_w);
            if (j == 18) read_all("R3 R7 new words after load", w);
            if (j >= 19) chk("R6 no follow-on readout", {31'h0, sclk_en}, 32'h0);
            conv_done = poke && (j == 4 || j == 17);
        end
        conv_done = 1'b0;
        last_w = w;
    endtask

    // Address change alone moves rd_data (R7)
    task automatic t_addr_walk;
        for (int c = 3; c >= 0; c--) begin
            rd_addr = 2'(c);
            #1;
            chk("R7 combinational lane select", {16'h0, rd_data}, {16'h0, last_w[c]});
        end
    endtask

    initial begin
        t_reset();
        t_xfer({16'h0000, 16'hA5C3, 16'h7FFE, 16'h8001}, 1'b0);
        t_xfer({16'h7FFF, 16'h8000, 16'h1234, 16'hFFFF}, 1'b1);
        t_xfer({16'h0001, 16'hC33C, 16'h5AA5, 16'h8000}, 1'b0);
        t_addr_walk();
        t_xfer({16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000}, 1'b1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule